// File: doc/BRIEF.md
# Sliding Aperture Address Translator

This block lets a narrow bus-visible window reach any part of a larger on-board memory. Software programs a single 32-bit map register with two enables, an aperture-size code and a window base. Each request then carries an offset into the window. The translator keeps the low offset bits that fall inside the aperture, takes the high bits from the base, and forms the full local memory address.

The aperture is a power-of-two window: 1 MiB shifted left by the code. Software moves the base to slide the window across memory, one aperture at a time. The local memory size is a build-time parameter of at most 1 GiB. An aperture code that asks for more than that is clamped to the memory size.

Requests that arrive while mapping is off, or that translate past the end of memory, are not forwarded. They raise an error flag instead. Results are registered and appear one cycle after the request.

Top module: `win_xlat`

## Requirements
- R1: After reset the map register reads as zero, and `mem_valid_o` and `mem_err_o` are low.
- R2: A read of the map register returns the stored value with bits 31:30 and 19:8 forced to zero. All other bits read back as written: base 29:20, code 7:4, bits 3:2, register enable bit 1 and map enable bit 0.
- R3: A map write applies to requests in later cycles. A request in the same cycle as the write is translated with the previous value.
- R4: A request is translated only when map register bits 0 and 1 are both 1. Otherwise the result is an error with `mem_valid_o` low.
- R5: The aperture size is 2^(20+code) bytes, where code is map bits 7:4. Offset bits at and above that size are dropped.
- R6: The translated address is (offset AND mask) OR (base AND NOT mask). Here the base is map bits 29:20 placed at address bits 29:20, and mask = aperture size - 1.
- R7: When 20+code exceeds the memory size exponent `MEM_LOG2`, the aperture is clamped to 2^MEM_LOG2 bytes.
- R8: A translated address at or beyond 2^MEM_LOG2 gives an error and is not forwarded.
- R9: Every request produces exactly one result, either valid or error, in the cycle after it is presented. With no request, both flags are low.
- R10: `mem_valid_o` and `mem_err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Map register write strobe |
| reg_wdata_i | input | 32 | Map register write data |
| reg_rdata_o | output | 32 | Map register read value |
| req_valid_i | input | 1 | Request present |
| req_off_i | input | 30 | Window offset of the request |
| mem_valid_o | output | 1 | Translated address is valid |
| mem_err_o | output | 1 | Request rejected |
| mem_addr_o | output | 30 | Translated local address |

## Verification
Each request's result is due exactly one clock after the request is sampled. The register read value is due right after the edge that stores a write.

For every request, the driver pushes the expected flags and address onto a queue. The monitor notes whether a request was present at each rising edge, then samples the outputs shortly after that edge. If a request was present, the monitor pops and compares one item; otherwise it requires both flags to be low.

Register read-back is sampled on the falling edge after the write. The same-cycle write-and-request case takes its expected value from the model's map value before the write.

// File: rtl/win_xlat_pkg.sv
package win_xlat_pkg;
  localparam int ADDR_W   = 30;
  localparam int MIB_LOG2 = 20;
  localparam int BASE_W   = ADDR_W - MIB_LOG2;
  localparam int CODE_W   = 4;
  localparam logic [31:0] MAP_KEEP = 32'h3FF0_00FF;

  typedef struct packed {
    logic [1:0]        rsv_hi;
    logic [BASE_W-1:0] base;
    logic [11:0]       rsv_mid;
    logic [CODE_W-1:0] code;
    logic [1:0]        spare;
    logic              reg_en;
    logic              map_en;
  } map_reg_t;
endpackage

// File: rtl/win_map_reg.sv
module win_map_reg
  import win_xlat_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output map_reg_t    map_o,
  output logic [31:0] rdata_o
);
  logic [31:0] map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   map_q <= '0;
    else if (we_i) map_q <= wdata_i & MAP_KEEP;
  end

  assign map_o   = map_reg_t'(map_q);
  assign rdata_o = map_q;

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[31:30] == 2'b0 && rdata_o[19:8] == 12'b0 &&
              rdata_o[29:20] == $past(wdata_i[29:20]) && rdata_o[7:0] == $past(wdata_i[7:0])));
endmodule

// File: rtl/win_ap_decode.sv
module win_ap_decode
  import win_xlat_pkg::*;
#(
  parameter int MEM_LOG2 = 26
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [ADDR_W-1:0] lo_mask_o
);
  localparam int AP_W = 6;
  logic [AP_W-1:0] ap_raw, ap_eff;

  always_comb begin
    ap_raw = AP_W'(MIB_LOG2) + AP_W'(code_i);
    ap_eff = (ap_raw > AP_W'(MEM_LOG2)) ? AP_W'(MEM_LOG2) : ap_raw;
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    assign lo_mask_o[i] = (AP_W'(i) < ap_eff);
  end
endmodule

// File: rtl/win_xlat_core.sv
module win_xlat_core
  import win_xlat_pkg::*;
#(
  parameter int MEM_LOG2 = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  map_reg_t          map_i,
  input  logic [ADDR_W-1:0] lo_mask_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_off_i,
  output logic              mem_valid_o,
  output logic              mem_err_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  logic [ADDR_W-1:0] base_full, addr_c;
  logic              in_range, enabled;

  assign base_full = {map_i.base, {MIB_LOG2{1'b0}}};
  assign addr_c    = (req_off_i & lo_mask_i) | (base_full & ~lo_mask_i);
  assign enabled   = map_i.map_en & map_i.reg_en;

  if (MEM_LOG2 < ADDR_W) begin : g_rng
    assign in_range = ~|addr_c[ADDR_W-1:MEM_LOG2];
  end else begin : g_full
    assign in_range = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_valid_o <= 1'b0;
      mem_err_o   <= 1'b0;
      mem_addr_o  <= '0;
    end else begin
      mem_valid_o <= req_valid_i & enabled & in_range;
      mem_err_o   <= req_valid_i & ~(enabled & in_range);
      if (req_valid_i & enabled & in_range) mem_addr_o <= addr_c;
    end
  end

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_valid_o && mem_err_o));
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!mem_valid_o && !mem_err_o));
  a_r4_disabled_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !(map_i.map_en && map_i.reg_en)) |=> (mem_err_o && !mem_valid_o));
  a_r8_in_memory: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> ((64'(mem_addr_o) >> MEM_LOG2) == 64'd0));
endmodule

// File: rtl/win_xlat.sv
module win_xlat
  import win_xlat_pkg::*;
#(
  parameter int MEM_LOG2 = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_off_i,
  output logic              mem_valid_o,
  output logic              mem_err_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  map_reg_t          map;
  logic [ADDR_W-1:0] lo_mask;

  initial begin
    if (MEM_LOG2 < MIB_LOG2 || MEM_LOG2 > ADDR_W)
      $error("MEM_LOG2 out of range");
  end

  win_map_reg i_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .map_o  (map),
    .rdata_o(reg_rdata_o)
  );

  win_ap_decode #(.MEM_LOG2(MEM_LOG2)) i_dec (
    .code_i   (map.code),
    .lo_mask_o(lo_mask)
  );

  win_xlat_core #(.MEM_LOG2(MEM_LOG2)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .map_i      (map),
    .lo_mask_i  (lo_mask),
    .req_valid_i(req_valid_i),
    .req_off_i  (req_off_i),
    .mem_valid_o(mem_valid_o),
    .mem_err_o  (mem_err_o),
    .mem_addr_o (mem_addr_o)
  );
endmodule

// File: tb/test_win_xlat.sv
module test_win_xlat;
  localparam int MEM_LOG2 = 26;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [29:0] req_off_i = '0;
  logic        mem_valid_o, mem_err_o;
  logic [29:0] mem_addr_o;

  always #2.5 clk_i = ~clk_i;

  win_xlat #(.MEM_LOG2(MEM_LOG2)) i_win_xlat (.*);

  typedef struct packed { logic v; logic e; logic [29:0] a; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int    total = 0, bad = 0;
  bit    done = 0;
  logic [31:0] bmap = '0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(logic [31:0] m, logic [29:0] off);
    exp_t r;
    int ap;
    longint mask, addr;
    ap = 20 + int'(m[7:4]);
    if (ap > MEM_LOG2) ap = MEM_LOG2;
    mask = (64'd1 << ap) - 1;
    addr = (longint'(off) & mask) | (longint'(m & 32'h3FF0_0000) & ~mask);
    r.a = addr[29:0];
    r.v = (m[1:0] == 2'b11) && (addr < (64'd1 << MEM_LOG2));
    r.e = !r.v;
    if (!r.v) r.a = '0;
    return r;
  endfunction

  task automatic wr_map(logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    bmap = d & 32'h3FF0_00FF;
  endtask

  task automatic do_req(logic [29:0] off, string tag);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_off_i = off;
    exp_q.push_back(model(bmap, off)); tag_q.push_back(tag);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // write and request in the same cycle: expectation uses the old map (R3)
  task automatic wr_and_req(logic [31:0] d, logic [29:0] off);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = d;
    req_valid_i = 1'b1; req_off_i = off;
    exp_q.push_back(model(bmap, off)); tag_q.push_back("R3 same-cycle old map");
    @(negedge clk_i);
    reg_we_i = 1'b0; req_valid_i = 1'b0;
    bmap = d & 32'h3FF0_00FF;
  endtask

  // monitor / scoreboard
  always @(posedge clk_i) begin
    bit had;
    had = req_valid_i && rst_ni;
    #1;
    if (rst_ni && !done) begin
      if (had) begin
        exp_t e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(mem_valid_o == e.v && mem_err_o == e.e, {t, " R9 R10 flags"},
            {mem_valid_o, mem_err_o}, {e.v, e.e});
        if (e.v) chk(mem_addr_o == e.a, {t, " addr"}, mem_addr_o, e.a);
      end else if (mem_valid_o || mem_err_o) begin
        chk(1'b0, "R9 idle result", {mem_valid_o, mem_err_o}, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(reg_rdata_o == 32'h0 && !mem_valid_o && !mem_err_o, "R1 reset state",
        {reg_rdata_o, mem_valid_o, mem_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(reg_rdata_o == 32'h0, "R1 map after reset", reg_rdata_o, 0);

    do_req(30'h12345, "R4 map off");
    wr_map(32'h0000_0001); do_req(30'h12345, "R4 only map_en");
    wr_map(32'h0000_0002); do_req(30'h12345, "R4 only reg_en");

    wr_map(32'hFFFF_FFFF);
    chk(reg_rdata_o == 32'h3FF0_00FF, "R2 readback mask", reg_rdata_o, 32'h3FF0_00FF);
    wr_map(32'h8A5A_5A5B);
    chk(reg_rdata_o == 32'h0A50_005B, "R2 readback pattern", reg_rdata_o, 32'h0A50_005B);

    wr_map(32'h0050_0003);
    do_req(30'h0012345, "R5 R6 1MiB window");
    do_req(30'h3FF_FFFF, "R5 offset bits dropped");
    wr_map(32'h0070_0023);
    do_req(30'h02A_BCDE, "R6 4MiB base low bits masked");
    wr_map(32'h3FF0_0063);
    do_req(30'h3FF_FFFF, "R7 64MiB window exact");
    wr_map(32'h1230_0093);
    do_req(30'h3FF_FFFF, "R7 clamp 512MiB to memory");
    do_req(30'h000_0000, "R7 clamp low end");
    wr_map(32'h03F0_0003);
    do_req(30'h00F_FFFF, "R8 last byte in memory");
    wr_map(32'h0400_0003);
    do_req(30'h000_0000, "R8 first byte past memory");
    wr_map(32'h3FF0_0003);
    do_req(30'h000_1000, "R8 far past memory");

    wr_map(32'h0010_0003);
    wr_and_req(32'h0020_0003, 30'h0000_0ABC);
    do_req(30'h0000_0ABC, "R3 next request new map");
    wr_and_req(32'h0000_0000, 30'h0000_0111);
    do_req(30'h0000_0111, "R3 R4 disabled after write");

    for (int i = 0; i < 60; i++) begin
      logic [31:0] m;
      m = $urandom;
      m[1:0] = ($urandom % 4 == 0) ? m[1:0] : 2'b11;
      m[29:26] = ($urandom % 2 == 0) ? 4'h0 : m[29:26];
      wr_map(m);
      do_req(30'($urandom), "R5 R6 R7 R8 sweep");
    end

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule